// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Port

This block gives a host a two-register window into a packet buffer RAM. The host first writes a 16-bit pointer word. That word holds a byte offset, a read/write direction, an auto-advance enable and a flag that says where the packet number comes from. The host then moves data through a data port, one byte or one 16-bit word per access. The packet number is never written with the pointer. It is taken live from one of two inputs: the head of the receive queue, or the current transmit packet number. Allocation and queue handling sit outside the block.

In read direction a prefetch register holds the two bytes at the pointer. Reads therefore complete with no wait once the prefetch is primed. Every accepted read refills the register from the advanced address, so back-to-back reads stream. A packet in the buffer normally starts with a 16-bit status word at offset 0 and an 11-bit byte count at offset 2, followed by the two MAC addresses. After the payload comes a trailing control byte whose bit 5 flags an odd length and whose bit 4 asks for CRC insertion. The port moves these bytes without interpreting them.

Top module: `pkt_mem_port`

## Requirements
- R1: After reset the pointer reads back as 0x0000 and `dir_err` is 0.
- R2: A write with `bus_sel`=0 loads all 16 bits of the pointer, and a read with `bus_sel`=0 returns them unchanged. Bits [10:0] hold the byte offset, bit 13 set means read direction, bit 14 set enables auto-advance and bit 15 selects the packet source.
- R3: When pointer bit 15 is 1, data accesses use packet `rxq_head`. When it is 0, they use packet `txpkt_num`.
- R4: A word access on the data port (`bus_sel`=1, `bus_word`=1) is little-endian: bits [7:0] go with the pointed offset and bits [15:8] with offset+1, for even and odd offsets alike. Only the low log2(PKT_BYTES) offset bits address the RAM.
- R5: A byte access on the data port (`bus_word`=0) stores `bus_wdata[7:0]` at the offset. On a read it returns that byte in `bus_rdata[7:0]`, with `bus_rdata[15:8]` = 0.
- R6: An accepted data access with bit 14 set adds 1 (byte) or 2 (word) to the 11-bit offset, wrapping modulo 2048 and leaving bits [15:11] unchanged. With bit 14 clear the pointer does not change.
- R7: In read direction, data is valid from the second cycle after the pointer write. Reads issued on consecutive cycles then return consecutive data.
- R8: A data-port write in read direction leaves the memory and the pointer unchanged and sets `dir_err`. A data-port read in write direction returns 0, leaves the pointer unchanged and sets `dir_err`.
- R9: `dir_err` stays set through later accepted accesses and is cleared only by a pointer write.
- R10: `bus_sel`=2 is a second byte lane on the same data stream. It always acts as a byte access, whatever `bus_word` says.
- R11: `bus_sel`=3 is unused: writes there change nothing and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select: 0 pointer, 1 data, 2 byte lane, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 for a 16-bit data access, 0 for a byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| txpkt_num | input | PKT_W | Transmit packet number |
| rxq_head | input | PKT_W | Packet number at the head of the receive queue |
| dir_err | output | 1 | Sticky direction-mismatch flag |

## Verification
A corrupted pointer shows up at once. The pointer reads back through the same port, so a wrong step, a lost upper bit or an advance on a rejected access is visible on the next pointer read. A stale or misaddressed prefetch appears as wrong data on the first read after the pointer write, or on the first read of a back-to-back run. A wrong packet-source choice shows as data from the other packet. The checks use packets with different contents, so that case is caught within one access. A missed or misplaced error update changes `dir_err` the cycle after the offending access.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int PTR_W   = 16;
  localparam int OFS_W   = 11;
  localparam int BYTE_W  = 8;
  localparam int BIT_RD  = 13;
  localparam int BIT_INC = 14;
  localparam int BIT_RXQ = 15;

  typedef enum logic [1:0] {
    PORT_PTR    = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_LANE_B = 2'd2,
    PORT_NONE   = 2'd3
  } port_sel_e;

  // offset step: one byte or one word, wrapping inside the offset field
  function automatic logic [OFS_W-1:0] ofs_advance(input logic [OFS_W-1:0] ofs,
                                                   input logic is_word);
    return ofs + (is_word ? OFS_W'(2) : OFS_W'(1));
  endfunction

  // packet index from the live sources
  function automatic logic [7:0] pick_pkt(input logic from_rxq,
                                          input logic [7:0] rxq,
                                          input logic [7:0] txp);
    return from_rxq ? rxq : txp;
  endfunction
endpackage

// File: rtl/pmp_ptr_ctl.sv
module pmp_ptr_ctl
  import pmp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic             is_word,
  output logic [PTR_W-1:0] ptr_q,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             pf_kick,
  output logic             cur_rxq,
  output logic [IDX_W-1:0] cur_idx,
  output logic             nxt_rxq,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             dir_err
);
  logic [PTR_W-1:0] ptr_d;
  logic             rd_mode;
  logic             reject;
  logic             advance;
  logic             err_d;

  assign rd_mode = ptr_q[BIT_RD];
  assign wr_ok   = data_wr & ~rd_mode;
  assign rd_ok   = data_rd & rd_mode;
  assign reject  = (data_wr & rd_mode) | (data_rd & ~rd_mode);
  assign advance = (wr_ok | rd_ok) & ptr_q[BIT_INC];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr) begin
      ptr_d = ptr_wdata;
    end else if (advance) begin
      ptr_d[OFS_W-1:0] = ofs_advance(ptr_q[OFS_W-1:0], is_word);
    end
  end

  always_comb begin
    err_d = dir_err;
    if (ptr_wr) begin
      err_d = 1'b0;
    end else if (reject) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      dir_err <= 1'b0;
      pf_kick <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      dir_err <= err_d;
      pf_kick <= ptr_wr & ptr_wdata[BIT_RD];
    end
  end

  assign cur_rxq = ptr_q[BIT_RXQ];
  assign cur_idx = ptr_q[IDX_W-1:0];
  assign nxt_rxq = ptr_d[BIT_RXQ];
  assign nxt_idx = ptr_d[IDX_W-1:0];

  assert_hold_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(ptr_q));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> dir_err);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> !dir_err);

  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok | rd_ok) |=> $stable(ptr_q[PTR_W-1:OFS_W]));

  assert_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ok | rd_ok) && !ptr_q[BIT_INC]) |=> $stable(ptr_q));
endmodule

// File: rtl/pmp_byte_ram.sv
module pmp_byte_ram
  import pmp_pkg::*;
#(
  parameter int NUM_PKTS  = 4,
  parameter int PKT_BYTES = 256,
  parameter int PKT_W     = $clog2(NUM_PKTS),
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              we_hi,
  input  logic [PKT_W-1:0]  wpkt,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wlo,
  input  logic [BYTE_W-1:0] whi,
  input  logic [PKT_W-1:0]  rpkt,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rlo,
  output logic [BYTE_W-1:0] rhi
);
  localparam int DEPTH = NUM_PKTS * PKT_BYTES;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  widx_up;
  logic [IDX_W-1:0]  ridx_up;

  assign widx_up = widx + IDX_W'(1);
  assign ridx_up = ridx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[{wpkt, widx}] <= wlo;
    end
    if (we && we_hi) begin
      mem[{wpkt, widx_up}] <= whi;
    end
  end

  assign rlo = mem[{rpkt, ridx}];
  assign rhi = mem[{rpkt, ridx_up}];

  assert_hi_lane_needs_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |-> we);
endmodule

// File: rtl/pmp_prefetch.sv
module pmp_prefetch
  import pmp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BYTE_W-1:0]   lo,
  input  logic [BYTE_W-1:0]   hi,
  output logic [2*BYTE_W-1:0] pf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= '0;
    end else if (load) begin
      pf_q <= {hi, lo};
    end
  end

  assert_pf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pf_q));
endmodule

// File: rtl/pkt_mem_port.sv
module pkt_mem_port
  import pmp_pkg::*;
#(
  parameter int NUM_PKTS  = 4,
  parameter int PKT_BYTES = 256,
  parameter int PKT_W     = $clog2(NUM_PKTS),
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_word,
  input  logic [PTR_W-1:0] bus_wdata,
  output logic [PTR_W-1:0] bus_rdata,
  input  logic [PKT_W-1:0] txpkt_num,
  input  logic [PKT_W-1:0] rxq_head,
  output logic             dir_err
);
  port_sel_e           sel;
  logic                on_data;
  logic                eff_word;
  logic                ptr_wr;
  logic                data_wr;
  logic                data_rd;
  logic [PTR_W-1:0]    ptr_q;
  logic                wr_ok;
  logic                rd_ok;
  logic                pf_kick;
  logic                cur_rxq;
  logic                nxt_rxq;
  logic [IDX_W-1:0]    cur_idx;
  logic [IDX_W-1:0]    nxt_idx;
  logic [PKT_W-1:0]    acc_pkt;
  logic [PKT_W-1:0]    fetch_pkt;
  logic [BYTE_W-1:0]   rd_lo;
  logic [BYTE_W-1:0]   rd_hi;
  logic                pf_load;
  logic [2*BYTE_W-1:0] pf_q;
  logic                rd_mode;

  assign sel      = port_sel_e'(bus_sel);
  assign on_data  = (sel == PORT_DATA) || (sel == PORT_LANE_B);
  assign eff_word = (sel == PORT_DATA) && bus_word;
  assign ptr_wr   = bus_wr && (sel == PORT_PTR);
  assign data_wr  = bus_wr && on_data;
  assign data_rd  = bus_rd && !bus_wr && on_data;

  pmp_ptr_ctl #(.IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (bus_wdata),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .is_word   (eff_word),
    .ptr_q     (ptr_q),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .pf_kick   (pf_kick),
    .cur_rxq   (cur_rxq),
    .cur_idx   (cur_idx),
    .nxt_rxq   (nxt_rxq),
    .nxt_idx   (nxt_idx),
    .dir_err   (dir_err)
  );

  assign acc_pkt   = PKT_W'(pick_pkt(cur_rxq, 8'(rxq_head), 8'(txpkt_num)));
  assign fetch_pkt = PKT_W'(pick_pkt(nxt_rxq, 8'(rxq_head), 8'(txpkt_num)));

  pmp_byte_ram #(
    .NUM_PKTS  (NUM_PKTS),
    .PKT_BYTES (PKT_BYTES),
    .PKT_W     (PKT_W),
    .IDX_W     (IDX_W)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_ok),
    .we_hi (wr_ok && eff_word),
    .wpkt  (acc_pkt),
    .widx  (cur_idx),
    .wlo   (bus_wdata[BYTE_W-1:0]),
    .whi   (bus_wdata[2*BYTE_W-1:BYTE_W]),
    .rpkt  (fetch_pkt),
    .ridx  (nxt_idx),
    .rlo   (rd_lo),
    .rhi   (rd_hi)
  );

  assign pf_load = pf_kick || rd_ok;

  pmp_prefetch u_pf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pf_load),
    .lo    (rd_lo),
    .hi    (rd_hi),
    .pf_q  (pf_q)
  );

  assign rd_mode = ptr_q[BIT_RD];

  always_comb begin
    bus_rdata = '0;
    case (sel)
      PORT_PTR:    bus_rdata = ptr_q;
      PORT_DATA:   if (rd_mode) bus_rdata = bus_word ? pf_q : {8'h00, pf_q[BYTE_W-1:0]};
      PORT_LANE_B: if (rd_mode) bus_rdata = {8'h00, pf_q[BYTE_W-1:0]};
      default:     bus_rdata = '0;
    endcase
  end

  assert_prime_after_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && bus_wdata[BIT_RD]) |=> pf_load);

  assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PORT_NONE) |=> ($stable(ptr_q) && $stable(dir_err)));
endmodule

// File: tb/sim_pkt_mem_port.sv
module sim_pkt_mem_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  txpkt_num = '0;
  logic [1:0]  rxq_head = '0;
  logic        dir_err;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  pkt_mem_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .txpkt_num (txpkt_num),
    .rxq_head  (rxq_head),
    .dir_err   (dir_err)
  );

  localparam logic [1:0] S_PTR = 2'd0, S_DATA = 2'd1, S_LB = 2'd2, S_NONE = 2'd3;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, input logic w, output logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_word = w; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    bus_write(S_PTR, 1'b1, p);
    @(posedge clk); #1;
  endtask

  task automatic check_ptr(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    bus_read(S_PTR, 1'b1, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    check_ptr("R1 pointer after reset", 16'h0000);
    check("R1 dir_err after reset", {15'd0, dir_err}, 16'h0000);
  endtask

  // packet 1 holds byte 0x10+k at offset k
  task automatic t_word_stream();
    logic [15:0] v;
    txpkt_num = 2'd1;
    set_ptr(16'h4000);
    for (int i = 0; i < 8; i++) bus_write(S_DATA, 1'b1, {8'(8'h11 + 2*i), 8'(8'h10 + 2*i)});
    check_ptr("R6 word advance by 2", 16'h4010);
    set_ptr(16'h6000);
    check_ptr("R2 pointer readback", 16'h6000);
    for (int i = 0; i < 8; i++) begin
      bus_read(S_DATA, 1'b1, v);
      check("R7 back-to-back word read", v, {8'(8'h11 + 2*i), 8'(8'h10 + 2*i)});
    end
    check_ptr("R6 read advance", 16'h6010);
    set_ptr(16'h6000);
    for (int i = 0; i < 4; i++) begin
      bus_read(S_DATA, 1'b0, v);
      check("R4 R5 little-endian byte read", v, {8'h00, 8'(8'h10 + i)});
    end
    check_ptr("R6 byte advance by 1", 16'h6004);
  endtask

  task automatic t_source_select();
    logic [15:0] v;
    txpkt_num = 2'd2;
    set_ptr(16'h4000);
    for (int i = 0; i < 4; i++) bus_write(S_DATA, 1'b0, {8'hFF, 8'(8'hC0 + i)});
    txpkt_num = 2'd0;
    set_ptr(16'h4000);
    for (int i = 0; i < 4; i++) bus_write(S_DATA, 1'b0, {8'hFF, 8'(8'h30 + i)});
    rxq_head = 2'd2; txpkt_num = 2'd0;
    set_ptr(16'hE000);
    bus_read(S_DATA, 1'b1, v);
    check("R3 bit15 uses receive head", v, 16'hC1C0);
    set_ptr(16'h6000);
    bus_read(S_DATA, 1'b1, v);
    check("R3 bit15 clear uses tx number", v, 16'h3130);
    rxq_head = 2'd0; txpkt_num = 2'd2;
    set_ptr(16'hE002);
    bus_read(S_DATA, 1'b1, v);
    check("R3 receive head follows input", v, 16'h3332);
  endtask

  task automatic t_no_advance();
    logic [15:0] v;
    txpkt_num = 2'd1;
    set_ptr(16'h2004);
    bus_read(S_DATA, 1'b1, v);
    check("R6 no-inc first read", v, 16'h1514);
    bus_read(S_DATA, 1'b1, v);
    check("R6 no-inc repeat read", v, 16'h1514);
    check_ptr("R6 no-inc pointer held", 16'h2004);
  endtask

  task automatic t_odd_word();
    logic [15:0] v;
    txpkt_num = 2'd3;
    set_ptr(16'h4021);
    bus_write(S_DATA, 1'b1, 16'hBEEF);
    set_ptr(16'h6021);
    bus_read(S_DATA, 1'b0, v);
    check("R4 odd offset low byte", v, 16'h00EF);
    bus_read(S_DATA, 1'b0, v);
    check("R4 odd offset high byte", v, 16'h00BE);
    check_ptr("R6 odd byte reads", 16'h6023);
  endtask

  task automatic t_direction();
    logic [15:0] v;
    txpkt_num = 2'd3;
    set_ptr(16'h4030);
    bus_write(S_DATA, 1'b1, 16'h5A5A);
    set_ptr(16'h2030);
    bus_write(S_DATA, 1'b1, 16'h1111);
    @(negedge clk);
    check("R8 write in read mode flags", {15'd0, dir_err}, 16'h0001);
    check_ptr("R8 write in read mode keeps pointer", 16'h2030);
    bus_read(S_DATA, 1'b1, v);
    check("R8 memory untouched", v, 16'h5A5A);
    @(negedge clk);
    check("R9 flag sticky", {15'd0, dir_err}, 16'h0001);
    set_ptr(16'h4040);
    @(negedge clk);
    check("R9 pointer write clears", {15'd0, dir_err}, 16'h0000);
    bus_read(S_DATA, 1'b1, v);
    check("R8 read in write mode returns 0", v, 16'h0000);
    @(negedge clk);
    check("R8 read in write mode flags", {15'd0, dir_err}, 16'h0001);
    check_ptr("R8 read in write mode keeps pointer", 16'h4040);
    set_ptr(16'h4040);
  endtask

  task automatic t_wrap();
    txpkt_num = 2'd3;
    set_ptr(16'h57FF);
    bus_write(S_DATA, 1'b0, 16'h0077);
    check_ptr("R6 byte wrap keeps upper bits", 16'h5000);
    set_ptr(16'h57FF);
    bus_write(S_DATA, 1'b1, 16'h1234);
    check_ptr("R6 word wrap", 16'h5001);
  endtask

  task automatic t_lane_b();
    logic [15:0] v;
    txpkt_num = 2'd1;
    set_ptr(16'h6000);
    bus_read(S_LB, 1'b1, v);
    check("R10 lane B reads a byte", v, 16'h0010);
    check_ptr("R10 lane B advances by 1", 16'h6001);
    set_ptr(16'h4008);
    bus_write(S_LB, 1'b1, 16'hABCD);
    check_ptr("R10 lane B write step", 16'h4009);
    set_ptr(16'h6008);
    bus_read(S_DATA, 1'b1, v);
    check("R10 lane B wrote one byte", v, 16'h19CD);
  endtask

  task automatic t_unused();
    logic [15:0] v;
    set_ptr(16'h4050);
    bus_write(S_NONE, 1'b1, 16'hFFFF);
    check_ptr("R11 unused write no pointer change", 16'h4050);
    @(negedge clk);
    check("R11 unused write no flag", {15'd0, dir_err}, 16'h0000);
    bus_read(S_NONE, 1'b1, v);
    check("R11 unused read zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_stream();
    t_source_select();
    t_no_advance();
    t_odd_word();
    t_direction();
    t_wrap();
    t_lane_b();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule